// File: doc/BRIEF.md
# Framed 16-bit serial command receiver

This block receives commands for a two-channel converter over a three-wire serial link. The three wires are an active-low frame select, a serial clock and a data line. All three wires are brought into the system clock domain through synchronizers. Falling edges of the serial clock are detected there, and the data line is sampled on each of them while the frame select is low.

A frame holds sixteen bits. Each completed frame is split into four fields: a channel select, a reference-buffer flag, a two-bit mode and a data field. The data field is `DATA_W` bits wide, where `DATA_W` is 8, 10 or 12.

A frame counts only if all sixteen falling edges arrive while the frame select is low. In that case the decoded fields are updated and a one-cycle write strobe marks which channel's input register takes the data. A frame cut short by an early release of the frame select leaves no trace. Clock edges after the sixteenth are ignored until the frame select has gone high and then low again. The system clock must run at least four times faster than the serial clock.

Top module: `sdac_cmd_rx`

## Requirements
- R1: After reset, `wr_stb`, `wr_chan`, `ref_buf`, `mode` and `wr_data` are all 0.
- R2: While `ser_sel_n` is low, `ser_din` is sampled on each falling edge of `ser_clk`. The first bit sampled is frame bit 15 (MSB first), and a frame is 16 bits.
- R3: Frame bit 15 drives `wr_chan` (0 = channel A, 1 = channel B).
- R4: Frame bit 14 drives `ref_buf`. Frame bits 13 and 12 drive `mode[1]` and `mode[0]`.
- R5: `wr_data` takes frame bits 11 down to 12-`DATA_W`, MSB first. The remaining 12-`DATA_W` low bits are ignored.
- R6: Each completed frame produces exactly one `wr_stb` pulse, one system clock wide. The new field values are present in the same cycle as the pulse. The pulse comes one system clock after the 16th falling edge is detected.
- R7: Serial clock edges and data after the 16th falling edge do not change any output. They also produce no further strobe until `ser_sel_n` has gone high and then low again.
- R8: If `ser_sel_n` rises before the 16th falling edge, no strobe is issued and all outputs keep their values.
- R9: While `ser_sel_n` is high, the bit count and the frame-done state are held cleared. The next frame is therefore decoded from its own first bit, even after an aborted frame.
- R10: Outputs other than `wr_stb` change only in a cycle where `wr_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; idles high, data taken on falling edges |
| ser_sel_n | input | 1 | Active-low frame select, level sensitive |
| ser_din | input | 1 | Serial data, MSB first |
| wr_stb | output | 1 | One-cycle write strobe for the selected channel's input register |
| wr_chan | output | 1 | Selected channel, 0 = A, 1 = B |
| ref_buf | output | 1 | Reference-buffer flag |
| mode | output | 2 | Mode field |
| wr_data | output | DATA_W | Data field |

## Verification
Two situations are hard to reach from the ports. The first is a frame select that stays low after sixteen edges while more serial clocks arrive. The second is a new frame that starts right after an aborted one. The first case needs the frame select held low with extra clock pulses that carry a distinctive data pattern; any shift of those bits into the fields, or a second strobe, would show at the outputs. The second case needs an abort after ten bits followed by a clean frame, whose fields show whether the leftover count was cleared. A second instance with an 8-bit data field shares the same stimulus, so that the dropping of the low bits is checked against the 12-bit instance.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned FIELD_MAX  = 12;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);

  typedef logic [FRAME_BITS-1:0] frame_t;

  typedef struct packed {
    logic                 chan;
    logic                 refb;
    logic [1:0]           mode;
    logic [FIELD_MAX-1:0] data;
  } cmd_t;

  // Channel select sits in the top bit of the frame.
  function automatic logic f_chan(input frame_t f);
    return f[15];
  endfunction

  function automatic logic f_refb(input frame_t f);
    return f[14];
  endfunction

  function automatic logic [1:0] f_mode(input frame_t f);
    return f[13:12];
  endfunction

  // Data field right-aligned for a width w; bits below the field are dropped.
  function automatic logic [FIELD_MAX-1:0] f_data(input frame_t f, input int unsigned w);
    logic [FIELD_MAX-1:0] raw;
    raw = f[FIELD_MAX-1:0];
    return raw >> (FIELD_MAX - w);
  endfunction

  function automatic cmd_t f_decode(input frame_t f, input int unsigned w);
    cmd_t c;
    c.chan = f_chan(f);
    c.refb = f_refb(f);
    c.mode = f_mode(f);
    c.data = f_data(f, w);
    return c;
  endfunction

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_in;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/sdac_edge.sv
module sdac_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  output logic fall
);

  logic sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b1;
    else        sclk_d <= sclk_s;
  end

  assign fall = sclk_d & ~sclk_s;

endmodule

// File: rtl/sdac_frame.sv
module sdac_frame
  import sdac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_hi,
  input  logic             fall,
  input  logic             din_s,
  output frame_t           word,
  output logic             frame_end,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);

  frame_t shreg;
  logic   take;

  assign done      = (cnt == CNT_W'(FRAME_BITS));
  assign take      = fall & ~sync_hi & ~done;
  assign frame_end = take & (cnt == CNT_W'(FRAME_BITS - 1));
  assign word      = {shreg[FRAME_BITS-2:0], din_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (sync_hi) begin
      cnt <= '0;
    end else if (take) begin
      shreg <= word;
      cnt   <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sdac_cmd_rx.sv
module sdac_cmd_rx
  import sdac_pkg::*;
#(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_sel_n,
  input  logic              ser_din,
  output logic              wr_stb,
  output logic              wr_chan,
  output logic              ref_buf,
  output logic [1:0]        mode,
  output logic [DATA_W-1:0] wr_data
);

  logic [2:0]       sync_bus;
  logic             sclk_s, sync_hi, din_s;
  logic             fall, frame_end, done;
  logic [CNT_W-1:0] cnt;
  frame_t           word;
  cmd_t             cmd;

  sdac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({ser_din, ser_sel_n, ser_clk}),
    .d_out (sync_bus)
  );

  assign sclk_s  = sync_bus[0];
  assign sync_hi = sync_bus[1];
  assign din_s   = sync_bus[2];

  sdac_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_s (sclk_s),
    .fall   (fall)
  );

  sdac_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_hi   (sync_hi),
    .fall      (fall),
    .din_s     (din_s),
    .word      (word),
    .frame_end (frame_end),
    .cnt       (cnt),
    .done      (done)
  );

  assign cmd = f_decode(word, DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_chan <= 1'b0;
      ref_buf <= 1'b0;
      mode    <= 2'b00;
      wr_data <= '0;
    end else begin
      wr_stb <= frame_end;
      if (frame_end) begin
        wr_chan <= cmd.chan;
        ref_buf <= cmd.refb;
        mode    <= cmd.mode;
        wr_data <= cmd.data[DATA_W-1:0];
      end
    end
  end

endmodule

// File: rtl/sdac_cmd_rx_chk.sv
module sdac_cmd_rx_chk
  import sdac_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_hi,
  input logic              fall,
  input logic              frame_end,
  input logic              done,
  input logic [CNT_W-1:0]  cnt,
  input logic              wr_stb,
  input logic              wr_chan,
  input logic              ref_buf,
  input logic [1:0]        mode,
  input logic [DATA_W-1:0] wr_data
);

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R6

  AST_STB_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> done || sync_hi); // R6

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hi |=> (cnt == '0)); // R9

  AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sync_hi) |=> $stable(cnt) && !frame_end); // R7

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_BITS)); // R2

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> $stable({wr_chan, ref_buf, mode, wr_data})); // R10

  AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> fall && !sync_hi); // R8

endmodule

bind sdac_cmd_rx sdac_cmd_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sync_hi   (sync_hi),
  .fall      (fall),
  .frame_end (frame_end),
  .done      (done),
  .cnt       (cnt),
  .wr_stb    (wr_stb),
  .wr_chan   (wr_chan),
  .ref_buf   (ref_buf),
  .mode      (mode),
  .wr_data   (wr_data)
);

// File: tb/tb_sdac_cmd_rx.sv
`timescale 1ns/1ps
module tb_sdac_cmd_rx;

  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b1, ser_sel_n = 1'b1, ser_din = 1'b0;

  logic        stb12, chan12, ref12;
  logic [1:0]  mode12;
  logic [11:0] data12;
  logic        stb8, chan8, ref8;
  logic [1:0]  mode8;
  logic [7:0]  data8;

  int n_chk = 0, n_bad = 0;
  int stb_cnt = 0, stb8_cnt = 0, wide_cnt = 0;
  logic stb_prev = 1'b0;

  always #2.5 clk = ~clk;

  sdac_cmd_rx #(.DATA_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n), .ser_din(ser_din),
    .wr_stb(stb12), .wr_chan(chan12), .ref_buf(ref12), .mode(mode12), .wr_data(data12));

  sdac_cmd_rx #(.DATA_W(8)) dut8 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n), .ser_din(ser_din),
    .wr_stb(stb8), .wr_chan(chan8), .ref_buf(ref8), .mode(mode8), .wr_data(data8));

  always @(posedge clk) begin
    if (stb12) stb_cnt <= stb_cnt + 1;
    if (stb8) stb8_cnt <= stb8_cnt + 1;
    if (stb12 && stb_prev) wide_cnt <= wide_cnt + 1;
    stb_prev <= stb12;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive nbits of w MSB first, then extra clocks carrying ones, optionally release.
  task automatic shift(input logic [15:0] w, input int nbits, input int extra);
    ser_sel_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits + extra; i++) begin
      ser_clk = 1'b1;
      ser_din = (i < nbits) ? w[15 - i] : 1'b1;
      wait_clk(HALF);
      ser_clk = 1'b0;
      wait_clk(HALF);
    end
    ser_clk = 1'b1;
    wait_clk(HALF);
    ser_sel_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic check_fields(input string tag, input logic [15:0] w);
    chk({tag, " R3 chan"}, chan12, w[15]);
    chk({tag, " R4 ref"}, ref12, w[14]);
    chk({tag, " R4 mode"}, mode12, w[13:12]);
    chk({tag, " R5 data12"}, data12, w[11:0]);
    chk({tag, " R5 data8"}, data8, w[11:4]);
  endtask

  task automatic t_reset();
    chk("R1 stb", stb12, 0);
    chk("R1 chan", chan12, 0);
    chk("R1 ref", ref12, 0);
    chk("R1 mode", mode12, 0);
    chk("R1 data", data12, 0);
  endtask

  task automatic t_frame(input string tag, input logic [15:0] w);
    int c0;
    c0 = stb_cnt;
    shift(w, 16, 0);
    chk({tag, " R6 one strobe"}, stb_cnt - c0, 1);
    check_fields({tag, " R2"}, w);
  endtask

  // Strobe timing: fields valid in the strobe cycle.
  task automatic t_strobe_timing(input logic [15:0] w);
    ser_sel_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 16; i++) begin
      ser_clk = 1'b1; ser_din = w[15 - i];
      wait_clk(HALF);
      ser_clk = 1'b0;
      if (i < 15) wait_clk(HALF);
    end
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (stb12) begin
        chk("R6 data in strobe cycle", data12, w[11:0]);
        chk("R6 chan in strobe cycle", chan12, w[15]);
      end
    end
    ser_clk = 1'b1;
    wait_clk(HALF);
    ser_sel_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic t_abort(input logic [15:0] w);
    int c0;
    logic [15:0] prev;
    c0 = stb_cnt;
    prev = {chan12, ref12, mode12, data12};
    shift(w, 10, 0);
    chk("R8 no strobe", stb_cnt - c0, 0);
    chk("R8 fields kept", {chan12, ref12, mode12, data12}, prev);
  endtask

  task automatic t_extra(input logic [15:0] w);
    int c0;
    c0 = stb_cnt;
    shift(w, 16, 9);
    chk("R7 single strobe with extra clocks", stb_cnt - c0, 1);
    check_fields("R7 extra ignored", w);
  endtask

  initial begin
    wait_clk(5);
    t_reset();
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_frame("A", 16'h3ABC);
    t_frame("B", 16'hC5A5);
    t_abort(16'hFFFF);
    t_frame("R9 after abort", 16'h4A31);
    t_extra(16'h6123);
    t_frame("R9 rearm", 16'h8FFF);
    t_strobe_timing(16'hB7E2);
    chk("R6 strobe never wider than one cycle", wide_cnt, 0);
    chk("R5 both widths strobed alike", stb8_cnt, stb_cnt);
    chk("R6 total strobes", stb_cnt, 6);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule